// File: doc/BRIEF.md
# HDLC Receive Path with Threshold-Interrupt FIFO

This block takes a serial HDLC bit stream, one bit per cycle in which the valid strobe is high, and turns it into stored bytes. It finds opening and closing flags, deletes stuffed zeros, stops a frame when it sees an abort sequence, and runs a CRC-16 over every frame. The first byte of each frame is the address byte. It is compared with two programmable match values, and a frame that fails the comparison never reaches storage.

Accepted bytes, including the two FCS bytes, go into a 128-entry receive FIFO. The FIFO shows its head entry on the read port at all times, and a one-cycle read strobe pops that entry. Each entry holds the data byte, an end-of-frame tag and a CRC-good flag; the flag is only meaningful on the tagged byte. A status bit sets when the fill level rises above a 7-bit threshold. It stays set until the FIFO has been emptied completely. A separate enable passes this status to an interrupt pin.

Top module: `hdlc_rx_top`

## Requirements
- R1: While `rx_en_i` is 0, valid bits are ignored and no byte is stored, even when the stream holds a complete frame.
- R2: Bytes between an opening flag 01111110 and a closing flag are stored in arrival order, with bits taken LSB first. The last byte of the frame (the second FCS byte) has `rd_eof_o`=1 and every earlier byte has it at 0.
- R3: Any 0 bit that follows five consecutive 1 bits inside a frame is deleted, so payload bytes such as 0xFF and 0x7E are recovered unchanged.
- R4: On the end-of-frame byte, `rd_crc_ok_o` is 1 when the CRC-16 (reflected 0x8408, initial value 0xFFFF, sent inverted, low byte first) matches and the frame length is a whole number of bytes. Otherwise it is 0.
- R5: With `match_en_i`=0, every frame is stored whatever its address byte.
- R6: With `match_en_i`=1 and `match_mode_i`=0, a frame is stored only when its first byte equals `addr_pri_i`.
- R7: With `match_en_i`=1 and `match_mode_i`=1, a frame is stored when its first byte equals either `addr_pri_i` or `addr_sec_i`.
- R8: Seven or more consecutive 1s end the current frame. The bytes already received stay stored, the last of them is tagged end-of-frame with `rd_crc_ok_o`=0, and the next flag starts a new frame normally.
- R9: `level_o` counts the stored entries, `empty_o` is 1 exactly when that count is 0, and each read strobe on a non-empty FIFO removes the head entry, oldest first.
- R10: `irq_stat_o` sets when `level_o` is greater than `thresh_i`. It stays 0 while the level equals the threshold.
- R11: Once set, `irq_stat_o` stays 1 while the level is above 0, including after it falls below the threshold. It clears when the FIFO is empty.
- R12: `irq_o` follows `irq_stat_o` only when `irq_en_i`=1. With `irq_en_i`=0, `irq_stat_o` can still be read.
- R13: A byte arriving while 128 entries are stored is dropped and the level stays at 128. `ovf_o` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| bit_i | input | 1 | Serial line bit |
| bit_vld_i | input | 1 | Bit strobe; `bit_i` is taken in cycles where this is 1 |
| match_en_i | input | 1 | Address comparison enable |
| match_mode_i | input | 1 | 0: primary address only, 1: primary or secondary |
| addr_pri_i | input | 8 | Primary address value |
| addr_sec_i | input | 8 | Secondary address value |
| thresh_i | input | 7 | Fill level above which the status sets |
| irq_en_i | input | 1 | Interrupt pin enable |
| rd_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head entry data byte |
| rd_eof_o | output | 1 | Head entry is the last byte of a frame |
| rd_crc_ok_o | output | 1 | Frame CRC good (valid with `rd_eof_o`) |
| empty_o | output | 1 | FIFO empty |
| level_o | output | 8 | Number of stored entries |
| irq_stat_o | output | 1 | Threshold status |
| irq_o | output | 1 | Interrupt pin |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The internal state shows up at the ports within a few cycles of the bit stream. A wrong count of consecutive ones either shifts every later byte by one bit position or breaks the frame apart at the closing flag, and this is visible in the first byte read back. Wrong CRC or address state shows as a missing frame or a wrong `rd_crc_ok_o` on the tagged byte once that frame has been drained. A fill counter that drifts from the true count shows at `level_o` and `empty_o` right away. Wrong status hold logic shows in the cycle after the threshold is crossed, or in the cycle after the FIFO is emptied.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef struct packed {
    logic       eof;
    logic       crc_ok;
    logic [7:0] data;
  } rx_entry_t;

  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;

  // reflected CRC-16, one byte, LSB first
  function automatic logic [15:0] crc16_byte(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          match_en_i,
  input  logic          match_mode_i,
  input  logic [AW-1:0] pri_i,
  input  logic [AW-1:0] sec_i,
  output logic          ok_o
);
  logic hit_pri, hit_sec;
  assign hit_pri = (addr_i == pri_i);
  assign hit_sec = (addr_i == sec_i);

  always_comb begin
    if (!match_en_i)       ok_o = 1'b1;
    else if (match_mode_i) ok_o = hit_pri | hit_sec;
    else                   ok_o = hit_pri;
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      bit_i,
  input  logic      vld_i,
  output logic [7:0] byte_o,
  input  logic      addr_ok_i,
  output logic      wr_o,
  output rx_entry_t entry_o
);
  logic [2:0]  ones_q, bcnt_q;
  logic        hunt_q, got_q, hvld_q, acc_q, wr_q;
  logic [7:0]  sr_q, hold_q;
  logic [15:0] crc_q;
  rx_entry_t   ent_q;

  logic step, is_stuff, is_flag, is_abort, take, done;
  logic [7:0] sr_n;

  assign step     = en_i & vld_i;
  assign is_stuff = step & ~bit_i & (ones_q == 3'd5);
  assign is_flag  = step & ~bit_i & (ones_q == 3'd6);
  assign is_abort = step &  bit_i & (ones_q == 3'd6);
  assign take     = step & ~hunt_q & ~is_stuff & ~is_flag & ~is_abort;
  assign sr_n     = {bit_i, sr_q[7:1]};
  assign done     = take & (bcnt_q == 3'd7);
  assign byte_o   = sr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      bcnt_q <= '0;
      hunt_q <= 1'b1;
      got_q  <= 1'b0;
      hvld_q <= 1'b0;
      acc_q  <= 1'b0;
      wr_q   <= 1'b0;
      sr_q   <= '0;
      hold_q <= '0;
      crc_q  <= CRC_INIT;
      ent_q  <= '0;
    end else begin
      wr_q <= 1'b0;
      if (!en_i) begin
        hunt_q <= 1'b1;
        hvld_q <= 1'b0;
        ones_q <= '0;
      end else if (vld_i) begin
        if (bit_i) ones_q <= (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
        else       ones_q <= '0;

        if (is_flag) begin
          if (!hunt_q && hvld_q && acc_q) begin
            wr_q  <= 1'b1;
            // seven flag bits sit in the partial byte when aligned
            ent_q <= '{eof: 1'b1,
                       crc_ok: (bcnt_q == 3'd7) && (crc_q == CRC_GOOD),
                       data: hold_q};
          end
          hunt_q <= 1'b0;
          bcnt_q <= '0;
          got_q  <= 1'b0;
          hvld_q <= 1'b0;
          crc_q  <= CRC_INIT;
        end else if (is_abort) begin
          if (!hunt_q && hvld_q && acc_q) begin
            wr_q  <= 1'b1;
            ent_q <= '{eof: 1'b1, crc_ok: 1'b0, data: hold_q};
          end
          hunt_q <= 1'b1;
          hvld_q <= 1'b0;
        end else if (take) begin
          sr_q   <= sr_n;
          bcnt_q <= bcnt_q + 3'd1;
          if (done) begin
            if (!got_q) acc_q <= addr_ok_i;
            if (hvld_q && acc_q) begin
              wr_q  <= 1'b1;
              ent_q <= '{eof: 1'b0, crc_ok: 1'b0, data: hold_q};
            end
            got_q  <= 1'b1;
            hold_q <= sr_n;
            hvld_q <= 1'b1;
            crc_q  <= crc16_byte(crc_q, sr_n);
          end
        end
      end
    end
  end

  assign wr_o    = wr_q;
  assign entry_o = ent_q;

  p_wr_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(en_i && vld_i));
  p_ok_only_eof_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && entry_o.crc_ok) |-> entry_o.eof);
  p_abort_fails_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(is_abort)) |-> (entry_o.eof && !entry_o.crc_ok));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic [CW-1:0] level_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, full, push, pop;

  assign full = (cnt_q == CW'(DEPTH));
  assign push = wr_i & ~full;
  assign pop  = rd_i & (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      if (pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
      if (wr_i && full) ovf_q <= 1'b1;
    end
  end

  assign rdata_o = mem[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign ovf_o   = ovf_q;

  p_level_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  p_pop_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !wr_i) |=> (level_o == $past(level_o) - CW'(1)));
  p_full_drop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !rd_i) |=> (level_o == CW'(DEPTH)));
  p_ovf_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/hdlc_rx_irq.sv
module hdlc_rx_irq #(
  parameter int LW = 8,
  parameter int TW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [TW-1:0] thresh_i,
  output logic          stat_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      stat_q <= 1'b0;
    else if (level_i == '0)           stat_q <= 1'b0;
    else if (level_i > LW'(thresh_i)) stat_q <= 1'b1;
  end

  assign stat_o = stat_q;

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && level_i != '0) |=> stat_o);
  p_irq_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> !stat_o);
  p_irq_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i > LW'(thresh_i)) |=> stat_o);
endmodule

// File: rtl/hdlc_rx_top.sv
module hdlc_rx_top
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int TH_W   = 7,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int ENT_W = $bits(rx_entry_t)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             match_en_i,
  input  logic             match_mode_i,
  input  logic [7:0]       addr_pri_i,
  input  logic [7:0]       addr_sec_i,
  input  logic [TH_W-1:0]  thresh_i,
  input  logic             irq_en_i,
  input  logic             rd_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_eof_o,
  output logic             rd_crc_ok_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic             irq_stat_o,
  output logic             irq_o,
  output logic             ovf_o
);
  logic [7:0] cand_byte;
  logic       addr_ok, wr;
  rx_entry_t  wr_ent, rd_ent;
  logic [ENT_W-1:0] rd_raw;
  logic [LVL_W-1:0] lvl;

  hdlc_addr_filter #(.AW(8)) u_filt (
    .addr_i(cand_byte), .match_en_i(match_en_i), .match_mode_i(match_mode_i),
    .pri_i(addr_pri_i), .sec_i(addr_sec_i), .ok_o(addr_ok)
  );

  hdlc_rx_deframer u_dfr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .bit_i(bit_i),
    .vld_i(bit_vld_i), .byte_o(cand_byte), .addr_ok_i(addr_ok),
    .wr_o(wr), .entry_o(wr_ent)
  );

  hdlc_rx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(wr_ent),
    .rd_i(rd_i), .rdata_o(rd_raw), .empty_o(empty_o), .level_o(lvl),
    .ovf_o(ovf_o)
  );

  hdlc_rx_irq #(.LW(LVL_W), .TW(TH_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(lvl), .thresh_i(thresh_i),
    .stat_o(irq_stat_o)
  );

  assign rd_ent      = rx_entry_t'(rd_raw);
  assign rd_data_o   = rd_ent.data;
  assign rd_eof_o    = rd_ent.eof;
  assign rd_crc_ok_o = rd_ent.crc_ok;
  assign level_o     = lvl;
  assign irq_o       = irq_stat_o & irq_en_i;
endmodule

// File: tb/hdlc_rx_top_test.sv
module hdlc_rx_top_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en_i = 1'b0, bit_i = 1'b1, bit_vld_i = 1'b0;
  logic match_en_i = 1'b0, match_mode_i = 1'b0;
  logic [7:0] addr_pri_i = 8'h00, addr_sec_i = 8'h00;
  logic [6:0] thresh_i = 7'd127;
  logic irq_en_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rd_data_o, level_o;
  logic rd_eof_o, rd_crc_ok_o, empty_o, irq_stat_o, irq_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  int ones_tx = 0;
  logic [7:0] fr [0:31];
  int fl = 0;

  always #5 clk_i = ~clk_i;

  hdlc_rx_top uut (.*);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    summary();
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b; bit_vld_i = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_raw(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    ones_tx = 0;
  endtask

  task automatic send_stuffed(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      ones_tx = v[i] ? ones_tx + 1 : 0;
      if (ones_tx == 5) begin
        send_bit(1'b0);
        ones_tx = 0;
      end
    end
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ fr[k][j]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  // fr[0..n-1] holds address+payload; appends FCS, fl = total length
  task automatic seal(input int n, input bit corrupt);
    logic [15:0] f = fcs_of(n);
    fr[n] = f[7:0]; fr[n+1] = f[15:8];
    if (corrupt) fr[n] = fr[n] ^ 8'h01;
    fl = n + 2;
  endtask

  task automatic send_frame();
    send_raw(8'h7E);
    for (int i = 0; i < fl; i++) send_stuffed(fr[i]);
    send_raw(8'h7E);
    idle(4);
  endtask

  task automatic pop();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic drain_frame(input string req, input logic exp_ok);
    for (int i = 0; i < fl; i++) begin
      chk(req, "data", rd_data_o, fr[i]);
      chk(req, "eof", rd_eof_o, (i == fl - 1));
      if (i == fl - 1) chk(req, "crc_ok", rd_crc_ok_o, exp_ok);
      pop();
    end
  endtask

  task automatic t_reset();
    chk("R9", "empty after reset", empty_o, 1);
    chk("R9", "level after reset", level_o, 0);
    chk("R11", "stat after reset", irq_stat_o, 0);
    chk("R13", "ovf after reset", ovf_o, 0);
  endtask

  task automatic t_disabled_r1();
    fr[0] = 8'h03; fr[1] = 8'h11; seal(2, 0);
    rx_en_i = 1'b0;
    send_frame();
    chk("R1", "level with rx off", level_o, 0);
    rx_en_i = 1'b1;
    idle(1);
  endtask

  task automatic t_basic_r2();
    fr[0] = 8'h03; fr[1] = 8'h11; fr[2] = 8'h22; seal(3, 0);
    send_frame();
    chk("R5", "frame stored with match off", level_o, 5);
    chk("R9", "not empty", empty_o, 0);
    drain_frame("R2", 1'b1);
    chk("R9", "empty after drain", empty_o, 1);
  endtask

  task automatic t_stuff_r3();
    fr[0] = 8'h7E; fr[1] = 8'hFF; fr[2] = 8'h7E; fr[3] = 8'h3F; fr[4] = 8'hF8;
    seal(5, 0);
    send_frame();
    chk("R3", "level", level_o, 7);
    drain_frame("R3", 1'b1);
  endtask

  task automatic t_badcrc_r4();
    fr[0] = 8'h09; fr[1] = 8'h5A; seal(2, 1);
    send_frame();
    chk("R4", "level", level_o, 4);
    drain_frame("R4", 1'b0);
  endtask

  task automatic t_match_pri_r6();
    match_en_i = 1'b1; match_mode_i = 1'b0;
    addr_pri_i = 8'h21; addr_sec_i = 8'h42;
    fr[0] = 8'h42; fr[1] = 8'h10; seal(2, 0);
    send_frame();
    chk("R6", "secondary dropped in primary mode", level_o, 0);
    fr[0] = 8'h21; seal(2, 0);
    send_frame();
    chk("R6", "primary accepted", level_o, 4);
    drain_frame("R6", 1'b1);
  endtask

  task automatic t_match_any_r7();
    match_en_i = 1'b1; match_mode_i = 1'b1;
    fr[0] = 8'h55; fr[1] = 8'h10; seal(2, 0);
    send_frame();
    chk("R7", "unmatched dropped", level_o, 0);
    fr[0] = 8'h42; seal(2, 0);
    send_frame();
    chk("R7", "secondary accepted", level_o, 4);
    drain_frame("R7", 1'b1);
    match_en_i = 1'b0;
  endtask

  task automatic t_abort_r8();
    fr[0] = 8'h05; fr[1] = 8'h11; fr[2] = 8'h22; fr[3] = 8'h33;
    send_raw(8'h7E);
    for (int i = 0; i < 4; i++) send_stuffed(fr[i]);
    send_raw(8'hFF);
    idle(4);
    chk("R8", "bytes kept after abort", level_o, 4);
    fl = 4;
    drain_frame("R8", 1'b0);
    fr[0] = 8'h06; fr[1] = 8'h44; seal(2, 0);
    send_frame();
    chk("R8", "frame after abort", level_o, 4);
    drain_frame("R8", 1'b1);
  endtask

  task automatic t_irq_r10();
    thresh_i = 7'd5; irq_en_i = 1'b0;
    fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h04; seal(3, 0);
    send_frame();
    chk("R10", "level at threshold", level_o, 5);
    chk("R10", "stat at threshold", irq_stat_o, 0);
    send_frame();
    chk("R10", "stat above threshold", irq_stat_o, 1);
    chk("R12", "pin gated off", irq_o, 0);
    irq_en_i = 1'b1;
    @(negedge clk_i);
    chk("R12", "pin enabled", irq_o, 1);
    repeat (6) pop();
    chk("R11", "level below threshold", level_o, 4);
    chk("R11", "stat held below threshold", irq_stat_o, 1);
    repeat (4) pop();
    @(negedge clk_i);
    chk("R11", "stat cleared when empty", irq_stat_o, 0);
    chk("R12", "pin cleared", irq_o, 0);
    thresh_i = 7'd127; irq_en_i = 1'b0;
  endtask

  task automatic t_overflow_r13();
    fr[0] = 8'hA0;
    for (int i = 1; i < 18; i++) fr[i] = 8'(i * 13);
    seal(18, 0);
    for (int k = 0; k < 7; k++) send_frame();
    chk("R13", "level saturates", level_o, 128);
    chk("R13", "overflow flag", ovf_o, 1);
    chk("R10", "stat at 128 over 127", irq_stat_o, 1);
    chk("R13", "oldest byte kept", rd_data_o, 8'hA0);
    pop();
    idle(2);
    chk("R13", "overflow sticky", ovf_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_disabled_r1();
    t_basic_r2();
    t_stuff_r3();
    t_badcrc_r4();
    t_match_pri_r6();
    t_match_any_r7();
    t_abort_r8();
    t_irq_r10();
    t_overflow_r13();
    summary();
  end
endmodule